// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Service

This block guards against software that has lost control. A prescaler divides the system clock into ticks and a window counter counts those ticks from the most recent restart. Software keeps the watchdog quiet by writing an 8-bit service word while the count lies inside a window. The window has a lower edge at one eighth of the selected upper limit, and it closes at that upper limit. A write that comes too soon, a write with the wrong key, or no write at all before the upper limit produces a one-cycle error pulse on `wd_err`. The error pulse also restarts the count. A reset generator elsewhere turns this pulse into a system reset.

The service word has three fields. Bits 7:6 choose the upper limit for the next window. Bits 5:1 must hold the key. Bit 0 turns on a clock monitor. Once enabled, the monitor counts system clocks between pulses of a slow reference tick and raises `cm_err` when a gap grows too long. The lower edge exists to catch a runaway loop that writes the service word too often.

Top module: `wwdt_keyed`

## Requirements
- R1: After reset, `wd_err` and `cm_err` are low, the largest window (select value 3) is in force and the clock monitor is off.
- R2: A write whose bits 5:1 differ from binary 01100 raises `wd_err` in the next cycle and restarts the count. The select and monitor settings stay as they were.
- R3: A correctly keyed write that arrives while the tick count is below one eighth of the current upper limit raises `wd_err` in the next cycle and restarts the count.
- R4: A correctly keyed write whose tick count is at or above the lower edge leaves `wd_err` low, restarts the count, and loads bits 7:6 as the new select and bit 0 as the monitor enable.
- R5: The upper limit is 2^(BASE_LOG2+sel) ticks, and one tick lasts PRESCALE clocks. If no write arrives, `wd_err` rises exactly upper·PRESCALE clocks after a restart.
- R6: `wd_err` is high for a single cycle for each violation, and the count starts again from zero at that point.
- R7: A write in the last clock before the upper limit expires is valid. It takes priority over the timeout, so no error occurs.
- R8: With the monitor enabled, `cm_err` goes high once more than CM_LIMIT clocks pass without a `ref_tick`. It returns low in the cycle after a `ref_tick`.
- R9: With the monitor disabled, `cm_err` stays low however long `ref_tick` is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| svc_we | input | 1 | Service write strobe |
| svc_data | input | 8 | Service word: [7:6] select, [5:1] key, [0] monitor enable |
| ref_tick | input | 1 | One-clock reference pulse for the clock monitor |
| wd_err | output | 1 | One-cycle watchdog violation pulse |
| cm_err | output | 1 | Clock monitor error flag |

## Verification
On every cycle, the assertions check four things. A bad key or an early write is followed by an error. A valid write produces no error and loads the new select. The count never reaches the current upper limit, and it is at zero whenever an error is present. For the monitor, they check that a reference tick or a disabled monitor keeps `cm_err` low. Some behaviours can only be shown by the bench's scenarios: the exact clock at which a timeout fires for each select value, the two sides of the lower edge, the last-clock write taking priority over the timeout, the monitor tripping after exactly CM_LIMIT+1 clocks, and a rejected write leaving the old window length in force.

// File: rtl/wwdt_keyed.sv
module wwdt_keyed #(
  parameter int PRESCALE  = 16,
  parameter int BASE_LOG2 = 13,
  parameter int CM_LIMIT  = 255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_we,
  input  logic [7:0] svc_data,
  input  logic       ref_tick,
  output logic       wd_err,
  output logic       cm_err
);
  localparam int CW = BASE_LOG2 + 4;
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int GW = $clog2(CM_LIMIT + 2);
  localparam logic [4:0] KEY = 5'b01100;

  logic [PW-1:0] pre_cnt;
  logic [CW-1:0] win_cnt;
  logic [1:0]    sel;
  logic          cm_en;
  logic [GW-1:0] gap;

  logic [CW-1:0] upper, lower;
  logic tick, key_ok, early, late, restart, viol;
  logic [GW-1:0] gap_nx;

  assign upper   = CW'(1) << (BASE_LOG2 + int'(sel));
  assign lower   = upper >> 3;
  assign tick    = (pre_cnt == PW'(PRESCALE - 1));
  assign key_ok  = (svc_data[5:1] == KEY);
  assign early   = (win_cnt < lower);
  assign late    = tick && (win_cnt == upper - CW'(1));
  assign restart = svc_we || late;
  assign viol    = svc_we ? (!key_ok || early) : late;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      win_cnt <= '0;
      sel     <= 2'd3;
      cm_en   <= 1'b0;
      wd_err  <= 1'b0;
    end else begin
      wd_err <= viol;
      if (restart) begin
        pre_cnt <= '0;
        win_cnt <= '0;
      end else if (tick) begin
        pre_cnt <= '0;
        win_cnt <= win_cnt + CW'(1);
      end else begin
        pre_cnt <= pre_cnt + PW'(1);
      end
      if (svc_we && !viol) begin
        sel   <= svc_data[7:6];
        cm_en <= svc_data[0];
      end
    end
  end

  assign gap_nx = ref_tick ? '0 :
                  (gap == GW'(CM_LIMIT + 1)) ? gap : gap + GW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap    <= '0;
      cm_err <= 1'b0;
    end else begin
      gap    <= gap_nx;
      cm_err <= cm_en && (gap_nx > GW'(CM_LIMIT));
    end
  end
endmodule

// File: rtl/wwdt_keyed_chk.sv
module wwdt_keyed_chk #(
  parameter int BASE_LOG2 = 13,
  parameter int CW = BASE_LOG2 + 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          svc_we,
  input logic [7:0]    svc_data,
  input logic          ref_tick,
  input logic          wd_err,
  input logic          cm_err,
  input logic [CW-1:0] win_cnt,
  input logic          cm_en,
  input logic [1:0]    sel
);
  logic [CW-1:0] up_c, lo_c;
  assign up_c = CW'(1) << (BASE_LOG2 + int'(sel));
  assign lo_c = up_c >> 3;

  // R2
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_we && svc_data[5:1] != 5'b01100) |=> wd_err);
  // R3
  early_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_we && win_cnt < lo_c) |=> wd_err);
  // R4
  good_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_we && svc_data[5:1] == 5'b01100 && win_cnt >= lo_c)
      |=> (!wd_err && sel == $past(svc_data[7:6])));
  // R5
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt < up_c);
  // R6
  err_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_err |-> win_cnt == '0);
  // R8
  ref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> !cm_err);
  // R9
  cm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_en |=> !cm_err);
endmodule

bind wwdt_keyed wwdt_keyed_chk #(.BASE_LOG2(BASE_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .svc_we(svc_we), .svc_data(svc_data),
  .ref_tick(ref_tick), .wd_err(wd_err), .cm_err(cm_err),
  .win_cnt(win_cnt), .cm_en(cm_en), .sel(sel));

// File: tb/wwdt_keyed_bench.sv
module wwdt_keyed_bench;
  localparam int P = 3;
  localparam int B = 5;
  localparam int L = 20;

  logic clk = 1'b0, rst_n = 1'b0, svc_we = 1'b0, ref_tick = 1'b0;
  logic [7:0] svc_data = 8'h00;
  logic wd_err, cm_err;
  int tests = 0, fails = 0, elapsed = 0, msel = 3;

  always #5 clk = ~clk;

  wwdt_keyed #(.PRESCALE(P), .BASE_LOG2(B), .CM_LIMIT(L)) u_wwdt_keyed (
    .clk(clk), .rst_n(rst_n), .svc_we(svc_we), .svc_data(svc_data),
    .ref_tick(ref_tick), .wd_err(wd_err), .cm_err(cm_err));

  function automatic int upper_t(int s); return 1 << (B + s); endfunction
  function automatic bit exp_viol(int n, int s, bit kok);
    return !kok || (n / P) < (upper_t(s) >> 3);
  endfunction
  function automatic logic [7:0] word(int s, bit kok, bit cm);
    return {2'(s), kok ? 5'b01100 : 5'b10101, cm};
  endfunction

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); elapsed++; end
  endtask

  task automatic svc(string req, int s, bit kok, bit cm);
    bit v;
    v = exp_viol(elapsed, msel, kok);
    svc_we = 1'b1; svc_data = word(s, kok, cm);
    @(negedge clk);
    svc_we = 1'b0;
    check(req, wd_err, v);
    if (!v) msel = s;
    elapsed = 0;
  endtask

  task automatic timeout(string req);
    wait_n(upper_t(msel) * P - 1 - elapsed);
    check(req, wd_err, 1'b0);
    wait_n(1);
    check(req, wd_err, 1'b1);
    elapsed = 0;
  endtask

  task automatic pulse_ref();
    ref_tick = 1'b1; wait_n(1); ref_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 wd_err reset", wd_err, 1'b0);
    check("R1 cm_err reset", cm_err, 1'b0);
    rst_n = 1'b1; elapsed = 0;

    timeout("R1 R5 default window sel3");
    wait_n(1);
    check("R6 single-cycle pulse", wd_err, 1'b0);
    check("R9 monitor off after reset", cm_err, 1'b0);

    wait_n(200);
    svc("R2 bad key", 0, 1'b0, 1'b0);
    timeout("R2 select unchanged after bad key");

    wait_n((upper_t(3) >> 3) * P - 1);
    svc("R3 one tick early", 0, 1'b1, 1'b0);
    wait_n((upper_t(3) >> 3) * P);
    svc("R4 at lower edge", 0, 1'b1, 1'b0);
    timeout("R4 R5 new select 0");

    wait_n(upper_t(0) * P - 1);
    svc("R7 last clock write", 1, 1'b1, 1'b1);

    wait_n(30);
    pulse_ref();
    wait_n(L);
    check("R8 no trip at limit", cm_err, 1'b0);
    wait_n(1);
    check("R8 trip past limit", cm_err, 1'b1);
    pulse_ref();
    check("R8 clear on ref", cm_err, 1'b0);
    svc("R4 disable monitor", 1, 1'b1, 1'b0);
    wait_n(60);
    check("R9 disabled stays low", cm_err, 1'b0);

    for (int it = 0; it < 60; it++) begin
      int n;
      int s;
      bit k;
      n = $urandom_range(0, upper_t(msel) * P - 1);
      s = $urandom_range(0, 3);
      k = ($urandom_range(0, 9) < 8);
      wait_n(n);
      svc("R2 R3 R4 random service", s, k, 1'b0);
      if (it % 10 == 9) timeout("R5 random timeout");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule